// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for each beat of a four-beat burst on a synchronous memory. A burst-start strobe captures a full start address from the bus and the burst order. After that, each clock edge with the advance input active steps to the next beat. Only the low address bits are rewritten; the upper bits stay as loaded. When advance is inactive the burst is suspended and the current address is held.

Two orders are supported. The linear order counts the low bits up and wraps modulo four. The interleaved order XORs the start value with the beat count. The order is sampled together with the start address, so a burst always completes in the order it began with. Two independent active-low start strobes are provided, so that a processor-side and a controller-side address-status signal can both begin a burst.

Top module: `burst_addr_seq`

## Requirements
- R1: Between two burst starts, bits AW-1 down to 2 of `word_addr` keep the value of `addr_in` captured at the last start.
- R2: At a clock edge where `start_a_n` or `start_b_n` is low, `word_addr` becomes `addr_in` and `beat_idx` becomes 0, visible right after that edge.
- R3: With `order_sel` = 0 at the start (linear), each advance adds one to the low two bits modulo four; for example, a start of 01 gives 01, 10, 11, 00.
- R4: With `order_sel` = 1 at the start (interleaved), the low two bits equal the start value XOR `beat_idx`; for example, a start of 01 gives 01, 00, 11, 10, and a start of 10 gives 10, 11, 00, 01.
- R5: At an edge with both strobes high and `adv_n` low, `beat_idx` increases by one modulo four.
- R6: At an edge with both strobes high and `adv_n` high, `word_addr` and `beat_idx` keep their values (suspend).
- R7: An advance after the fourth beat returns to the start address with `beat_idx` = 0.
- R8: A start strobe takes priority over `adv_n` low in the same cycle.
- R9: A change of `order_sel` during a burst has no effect on that burst's sequence.
- R10: `rst_n` low clears `word_addr` and `beat_idx` to zero at once; the block leaves reset at the second rising clock edge after `rst_n` goes high, and ignores all strobes until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_a_n | input | 1 | Burst-start strobe, first source, active low |
| start_b_n | input | 1 | Burst-start strobe, second source, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | AW | External start address |
| word_addr | output | AW | Address of the current beat |
| beat_idx | output | 2 | Index of the current beat, 0 to 3 |

## Verification
On every cycle, the checker confirms the following. A start loads the external address at beat zero. A step adds one to the beat index and moves the low bits according to the order captured at the start. A suspend freezes both outputs. The upper bits never move without a start. The reset value is checked whenever internal reset is active. Only the directed scenarios show the following: the full four-beat sequences for particular start values, the wrap back to the first beat, that a start wins over an advance, that an order change mid-burst is ignored, and the delay of reset release.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } act_e;
endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic start_a_n,
  input  logic start_b_n,
  input  logic adv_n,
  output act_e act
);
  always_comb begin
    if (!start_a_n || !start_b_n) act = ACT_LOAD;
    else if (!adv_n)              act = ACT_STEP;
    else                          act = ACT_HOLD;
  end
endmodule

// File: rtl/bseq_lowmap.sv
module bseq_lowmap
  import bseq_pkg::*;
#(
  parameter int LOW_W = 2
) (
  input  logic [LOW_W-1:0] start_lo,
  input  logic [LOW_W-1:0] beat,
  input  order_e           ord,
  output logic [LOW_W-1:0] lo
);
  logic [LOW_W-1:0] lin_lo;
  logic [LOW_W-1:0] xor_lo;

  assign lin_lo = start_lo + beat;

  for (genvar i = 0; i < LOW_W; i++) begin : g_bit
    assign xor_lo[i] = start_lo[i] ^ beat[i];
  end

  assign lo = (ord == ORD_XOR) ? xor_lo : lin_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int AW         = 20,
  parameter int BURST_LEN  = 4,
  parameter int RST_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_a_n,
  input  logic                         start_b_n,
  input  logic                         adv_n,
  input  logic                         order_sel,
  input  logic [AW-1:0]                addr_in,
  output logic [AW-1:0]                word_addr,
  output logic [$clog2(BURST_LEN)-1:0] beat_idx
);
  localparam int LOW_W = $clog2(BURST_LEN);
  localparam logic [LOW_W-1:0] BEAT_ONE = LOW_W'(1);

  logic             rst_q_n;
  act_e             act;
  logic             upd_en;
  logic [AW-1:0]    base_q, base_d;
  logic [LOW_W-1:0] beat_q, beat_d;
  order_e           ord_q, ord_d;
  logic [LOW_W-1:0] cur_lo;

  bseq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_q_n (rst_q_n)
  );

  bseq_ctrl u_ctrl (
    .start_a_n (start_a_n),
    .start_b_n (start_b_n),
    .adv_n     (adv_n),
    .act       (act)
  );

  // next state
  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    ord_d  = ord_q;
    unique case (act)
      ACT_LOAD: begin
        base_d = addr_in;
        beat_d = '0;
        ord_d  = order_e'(order_sel);
      end
      ACT_STEP: beat_d = beat_q + BEAT_ONE;
      default: ;
    endcase
  end

  assign upd_en = (act != ACT_HOLD);

  // state registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      base_q <= '0;
      beat_q <= '0;
      ord_q  <= ORD_XOR;
    end else if (upd_en) begin
      base_q <= base_d;
      beat_q <= beat_d;
      ord_q  <= ord_d;
    end
  end

  bseq_lowmap #(.LOW_W(LOW_W)) u_lowmap (
    .start_lo (base_q[LOW_W-1:0]),
    .beat     (beat_q),
    .ord      (ord_q),
    .lo       (cur_lo)
  );

  assign word_addr = {base_q[AW-1:LOW_W], cur_lo};
  assign beat_idx  = beat_q;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int AW    = 20,
  parameter int LOW_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_a_n,
  input logic             start_b_n,
  input logic             adv_n,
  input logic             order_sel,
  input logic [AW-1:0]    addr_in,
  input logic [AW-1:0]    word_addr,
  input logic [LOW_W-1:0] beat_idx
);
  localparam logic [LOW_W-1:0] ONE = LOW_W'(1);

  logic load;
  logic ord_sh;
  assign load = !start_a_n || !start_b_n;

  // the order seen by this checker at the last start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ord_sh <= 1'b1;
    else if (load) ord_sh <= order_sel;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_zero: assert (word_addr == '0 && beat_idx == '0)
        else $error("R10 reset state");
    end
  end

  a_r1_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_addr[AW-1:LOW_W]));

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (word_addr == $past(addr_in) && beat_idx == '0));

  a_r3_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n && !ord_sh) |=>
      word_addr[LOW_W-1:0] == $past(word_addr[LOW_W-1:0]) + ONE);

  a_r4_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n && ord_sh) |=>
      word_addr[LOW_W-1:0] == ($past(word_addr[LOW_W-1:0])
                               ^ $past(beat_idx) ^ ($past(beat_idx) + ONE)));

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n) |=> beat_idx == $past(beat_idx) + ONE);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> ($stable(word_addr) && $stable(beat_idx)));
endmodule

bind burst_addr_seq bseq_chk #(.AW(AW), .LOW_W(LOW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .start_a_n (start_a_n),
  .start_b_n (start_b_n),
  .adv_n     (adv_n),
  .order_sel (order_sel),
  .addr_in   (addr_in),
  .word_addr (word_addr),
  .beat_idx  (beat_idx)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_a_n, start_b_n, adv_n, order_sel;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] word_addr;
  logic [1:0]    beat_idx;
  int            total = 0;
  int            bad   = 0;
  bit            done  = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_a_n (start_a_n),
    .start_b_n (start_b_n),
    .adv_n     (adv_n),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .word_addr (word_addr),
    .beat_idx  (beat_idx)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [AW-1:0] ea, logic [1:0] eb);
    total++;
    if (word_addr !== ea || beat_idx !== eb) begin
      bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, word_addr, beat_idx, ea, eb);
    end
  endtask

  task automatic idle();
    start_a_n = 1'b1; start_b_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic load(bit use_b, logic [AW-1:0] a, bit ord);
    addr_in = a; order_sel = ord; adv_n = 1'b1;
    if (use_b) start_b_n = 1'b0; else start_a_n = 1'b0;
    tick();
    idle();
  endtask

  task automatic advance();
    adv_n = 1'b0;
    tick();
    adv_n = 1'b1;
  endtask

  task automatic t_reset();
    idle(); order_sel = 1'b0; addr_in = 20'hABCDE;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) tick();
    chk("R10 reset clears", '0, 2'd0);
    rst_n = 1'b1;
    start_a_n = 1'b0;       // first edge after release: still in reset
    tick();
    start_a_n = 1'b1;
    chk("R10 strobe ignored during release", '0, 2'd0);
    repeat (2) tick();
  endtask

  task automatic t_linear();
    load(1'b0, 20'h12341, 1'b0);
    chk("R2 load linear", 20'h12341, 2'd0);
    advance(); chk("R3 linear beat1", 20'h12342, 2'd1);
    advance(); chk("R3 linear beat2", 20'h12343, 2'd2);
    advance(); chk("R3 R1 linear beat3", 20'h12340, 2'd3);
    advance(); chk("R7 wrap linear", 20'h12341, 2'd0);
  endtask

  task automatic t_xor();
    load(1'b0, 20'hF00F1, 1'b1);
    chk("R2 load xor", 20'hF00F1, 2'd0);
    advance(); chk("R4 xor beat1", 20'hF00F0, 2'd1);
    advance(); chk("R4 xor beat2", 20'hF00F3, 2'd2);
    advance(); chk("R4 xor beat3", 20'hF00F2, 2'd3);
    advance(); chk("R7 wrap xor", 20'hF00F1, 2'd0);
    load(1'b1, 20'h55552, 1'b1);
    chk("R2 load via second strobe", 20'h55552, 2'd0);
    advance(); chk("R4 xor from 10 beat1", 20'h55553, 2'd1);
    advance(); chk("R4 xor from 10 beat2", 20'h55550, 2'd2);
    advance(); chk("R4 xor from 10 beat3", 20'h55551, 2'd3);
  endtask

  task automatic t_suspend();
    load(1'b0, 20'h0AAA2, 1'b0);
    advance();
    chk("R5 step", 20'h0AAA3, 2'd1);
    tick(); tick();
    chk("R6 suspend holds", 20'h0AAA3, 2'd1);
    advance();
    chk("R5 resume after suspend", 20'h0AAA0, 2'd2);
  endtask

  task automatic t_override();
    load(1'b0, 20'h33330, 1'b0);
    advance();
    addr_in = 20'h77773; order_sel = 1'b1;
    start_b_n = 1'b0; adv_n = 1'b0;
    tick();
    idle();
    chk("R8 start wins over advance", 20'h77773, 2'd0);
    advance();
    chk("R8 new burst xor beat1", 20'h77772, 2'd1);
  endtask

  task automatic t_order_latched();
    load(1'b0, 20'h22221, 1'b0);
    order_sel = 1'b1;
    advance(); chk("R9 order change ignored beat1", 20'h22222, 2'd1);
    advance(); chk("R9 order change ignored beat2", 20'h22223, 2'd2);
    addr_in = 20'hFFFFF;
    tick();
    chk("R1 addr_in change without start ignored", 20'h22223, 2'd2);
  endtask

  initial begin
    t_reset();
    t_linear();
    t_xor();
    t_suspend();
    t_override();
    t_order_latched();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule